// File: doc/BRIEF.md
# General-Purpose Up/Down Timer

A 16-bit timer controlled through a small register port: one write per clock, with combinational read-back. The input clock first passes through a programmable divider. The divided ticks then drive a counter. The counter can run in one of four modes:

- a plain single-direction mode, counting upward or downward as software chooses;
- three symmetric modes that count up to a programmable top value and back down to zero.

A wrap at either end of the count is an update event. Software can also force an update by writing a reload request, which re-seeds the counter according to the mode. An update flag records update events and, when enabled, drives an interrupt line. A compare flag records when the count reaches a programmed value. In the symmetric modes, the mode decides which counting direction may set the compare flag. A one-shot option stops the counter after its first wrap.

Top module: `gen_timer`

Register addresses (3-bit `addr`):

| Address | Register | Contents |
|---|---|---|
| 0 | CTRL | bit0 run, bit1 dir (1 = down), bits3:2 mode, bit4 update-off, bit5 quiet-software, bit6 one-shot |
| 1 | IEN | bit0 update interrupt enable |
| 2 | STAT | bit0 update flag, bit1 compare flag |
| 3 | RELOAD | bit0 reload request |
| 4 | COUNT | counter value |
| 5 | DIV | divider ratio minus one |
| 6 | TOP | top value |
| 7 | CMPV | compare value |

Mode encoding:

| Mode | Behaviour |
|---|---|
| 00 | Single direction, set by dir |
| 01 | Symmetric; compare flag sets only on downward steps |
| 10 | Symmetric; compare flag sets only on upward steps |
| 11 | Symmetric; compare flag sets on steps in either direction |

## Requirements
- R1: After reset every register at addresses 0 to 7 reads 0 and `irq` is low.
- R2: While run (CTRL bit0) is 1, the counter takes one step every DIV+1 clocks. While run is 0, the counter holds its value.
- R3: In mode 00 with dir=0, the counter counts 0..TOP and then wraps to 0; that wrap is an update event. With dir=1 it counts down, and the step from 0 loads TOP as an update event.
- R4: In modes 01, 10 and 11, the counter rises from 0 to TOP and then falls back to 0, repeating. The step away from TOP and the step away from 0 are update events. CTRL bit1 reads 1 while the counter is falling and 0 while it is rising, and writes to that bit are ignored.
- R5: A CTRL write that would move mode from 00 to a non-zero value while run is 1 leaves mode unchanged; the other CTRL fields of that write still take effect. The same write made while run is 0 is accepted.
- R6: Writing 1 to RELOAD bit0 clears the divider count and loads the counter. It loads TOP in mode 00 with dir=1, and 0 in every other case. In the symmetric modes it also sets the rising direction. RELOAD always reads 0.
- R7: The update flag (STAT bit0) sets on a wrap when update-off (CTRL bit4) is 0. It sets on a reload request only when both update-off and quiet-software (CTRL bit5) are 0. Writing 0 to STAT bit0 clears it; writing 1 leaves it unchanged.
- R8: `irq` is high exactly when the update flag and IEN bit0 are both 1.
- R9: The compare flag (STAT bit1) sets when a step lands on CMPV and the step direction is permitted by the mode: mode 00 any direction, 01 downward only, 10 upward only, 11 either direction. Writing 0 to STAT bit1 clears it.
- R10: With one-shot (CTRL bit6) set, a wrap clears run, so the counter stops on the wrapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr`, combinational |
| irq | output | 1 | Update interrupt request |

## Verification
The assertions take for granted that at most one register is written per clock. Because of this, a reload request can never coincide with a change of TOP, mode or direction, and the value loaded by a reload can be predicted from the state before the write. They also assume that reset is asserted before the first clock edge.

The stimulus stays within these assumptions:
- Every access goes through a single write task.
- The counter is stopped before DIV, TOP or CMPV is reprogrammed.
- TOP is kept at 1 or more.
- CMPV is kept inside 0..TOP, so each compare hit falls at a tick count the bench can compute.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        MODE_EDGE  = 2'b00,
        MODE_CDOWN = 2'b01,
        MODE_CUP   = 2'b10,
        MODE_CBOTH = 2'b11
    } cmode_e;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_IEN    = 3'd1,
        A_STAT   = 3'd2,
        A_RELOAD = 3'd3,
        A_COUNT  = 3'd4,
        A_DIV    = 3'd5,
        A_TOP    = 3'd6,
        A_CMPV   = 3'd7
    } addr_e;

    // Control word, bit 0 at the bottom of the list.
    typedef struct packed {
        logic   one_shot;
        logic   quiet_sw;
        logic   upd_off;
        cmode_e mode;
        logic   dir;
        logic   run;
    } ctrl_t;

    localparam int CTRL_BITS = $bits(ctrl_t);

    function automatic logic is_center(cmode_e m);
        return m != MODE_EDGE;
    endfunction

    // May a step in the given direction raise the compare flag?
    function automatic logic cmp_allowed(cmode_e m, logic down);
        case (m)
            MODE_CDOWN: return down;
            MODE_CUP:   return !down;
            default:    return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         clr,
    input  logic [W-1:0] ratio,
    output logic         tick
);

    logic [W-1:0] pcnt;

    // A lowered ratio still wraps at once, because of the >= compare.
    assign tick = run && !clr && (pcnt >= ratio);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (clr) begin
            pcnt <= '0;
        end else if (run) begin
            if (tick) pcnt <= '0;
            else      pcnt <= pcnt + W'(1);
        end
    end

endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         ug,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  cmode_e       mode,
    input  logic         dir_sw,
    input  logic [W-1:0] top,
    input  logic [W-1:0] cmpv,
    output logic [W-1:0] cnt,
    output logic         dir_now,
    output logic         wrap,
    output logic         cmp_hit
);

    logic         cdown;      // direction state of the symmetric modes
    logic         center;
    logic [W-1:0] nxt;
    logic         nxt_down;
    logic         at_end;
    logic         step_ok;

    assign center  = is_center(mode);
    assign dir_now = center ? cdown : dir_sw;

    always_comb begin
        nxt      = cnt;
        nxt_down = cdown;
        at_end   = 1'b0;
        if (!center) begin
            if (!dir_sw) begin
                if (cnt >= top) begin
                    nxt    = '0;
                    at_end = 1'b1;
                end else begin
                    nxt = cnt + W'(1);
                end
            end else begin
                if (cnt == '0) begin
                    nxt    = top;
                    at_end = 1'b1;
                end else begin
                    nxt = cnt - W'(1);
                end
            end
        end else begin
            if (!cdown) begin
                if (cnt >= top) begin
                    nxt      = (top == '0) ? '0 : top - W'(1);
                    nxt_down = 1'b1;
                    at_end   = 1'b1;
                end else begin
                    nxt = cnt + W'(1);
                end
            end else begin
                if (cnt == '0) begin
                    nxt      = (top == '0) ? '0 : W'(1);
                    nxt_down = 1'b0;
                    at_end   = 1'b1;
                end else begin
                    nxt = cnt - W'(1);
                end
            end
        end
    end

    // Register writes take precedence over a tick in the same cycle.
    assign step_ok = tick && !ug && !load;
    assign wrap    = step_ok && at_end;
    assign cmp_hit = step_ok && (nxt == cmpv)
                     && cmp_allowed(mode, center ? nxt_down : dir_sw);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            cdown <= 1'b0;
        end else if (ug) begin
            cnt   <= (center || !dir_sw) ? '0 : top;
            cdown <= 1'b0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt   <= nxt;
            cdown <= nxt_down;
        end
    end

endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      cnt,
    input  logic              dir_now,
    input  logic              wrap,
    input  logic              cmp_hit,
    output ctrl_t             ctrl,
    output logic              ien,
    output logic              upd_flag,
    output logic              cmp_flag,
    output logic [W-1:0]      ratio,
    output logic [W-1:0]      top,
    output logic [W-1:0]      cmpv,
    output logic              ug,
    output logic              load,
    output logic [W-1:0]      rdata
);

    addr_e a;
    ctrl_t wctrl;
    ctrl_t ctrl_d;
    ctrl_t rview;
    logic  upd_set;
    logic  wr_stat;

    assign a       = addr_e'(addr);
    assign ug      = wr_en && (a == A_RELOAD) && wdata[0];
    assign load    = wr_en && (a == A_COUNT);
    assign wr_stat = wr_en && (a == A_STAT);
    assign upd_set = !ctrl.upd_off && (wrap || (ug && !ctrl.quiet_sw));

    always_comb begin
        wctrl = ctrl_t'(wdata[CTRL_BITS-1:0]);
        // A running single-direction counter may not enter a symmetric mode.
        if (ctrl.run && (ctrl.mode == MODE_EDGE) && (wctrl.mode != MODE_EDGE))
            wctrl.mode = ctrl.mode;
        // The direction belongs to the hardware in the symmetric modes.
        if (is_center(wctrl.mode))
            wctrl.dir = ctrl.dir;
        ctrl_d = ctrl;
        if (wr_en && (a == A_CTRL))
            ctrl_d = wctrl;
        if (ctrl.one_shot && wrap)
            ctrl_d.run = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            ien      <= 1'b0;
            upd_flag <= 1'b0;
            cmp_flag <= 1'b0;
            ratio    <= '0;
            top      <= '0;
            cmpv     <= '0;
        end else begin
            ctrl <= ctrl_d;
            if (wr_en && (a == A_IEN)) ien   <= wdata[0];
            if (wr_en && (a == A_DIV)) ratio <= wdata;
            if (wr_en && (a == A_TOP)) top   <= wdata;
            if (wr_en && (a == A_CMPV)) cmpv <= wdata;
            // A hardware set in the same cycle wins over a software clear.
            if (upd_set)                    upd_flag <= 1'b1;
            else if (wr_stat && !wdata[0])  upd_flag <= 1'b0;
            if (cmp_hit)                    cmp_flag <= 1'b1;
            else if (wr_stat && !wdata[1])  cmp_flag <= 1'b0;
        end
    end

    always_comb begin
        rview     = ctrl;
        rview.dir = dir_now;
        rdata     = '0;
        case (a)
            A_CTRL:   rdata[CTRL_BITS-1:0] = rview;
            A_IEN:    rdata[0] = ien;
            A_STAT:   rdata[1:0] = {cmp_flag, upd_flag};
            A_RELOAD: rdata = '0;
            A_COUNT:  rdata = cnt;
            A_DIV:    rdata = ratio;
            A_TOP:    rdata = top;
            A_CMPV:   rdata = cmpv;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gen_timer.sv
`timescale 1ns/1ps
module gen_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq
);

    ctrl_t            ctrl_q;
    logic             ien_q;
    logic             upd_flag;
    logic             cmp_flag;
    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] top_val;
    logic [CNT_W-1:0] cmpv;
    logic [CNT_W-1:0] cnt;
    logic             ug;
    logic             load;
    logic             tick;
    logic             wrap;
    logic             cmp_hit;
    logic             dir_now;

    tmr_regs #(.W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .cnt      (cnt),
        .dir_now  (dir_now),
        .wrap     (wrap),
        .cmp_hit  (cmp_hit),
        .ctrl     (ctrl_q),
        .ien      (ien_q),
        .upd_flag (upd_flag),
        .cmp_flag (cmp_flag),
        .ratio    (ratio),
        .top      (top_val),
        .cmpv     (cmpv),
        .ug       (ug),
        .load     (load),
        .rdata    (rdata)
    );

    tmr_prescale #(.W(CNT_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl_q.run),
        .clr   (ug),
        .ratio (ratio),
        .tick  (tick)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .ug       (ug),
        .load     (load),
        .load_val (wdata),
        .mode     (ctrl_q.mode),
        .dir_sw   (ctrl_q.dir),
        .top      (top_val),
        .cmpv     (cmpv),
        .cnt      (cnt),
        .dir_now  (dir_now),
        .wrap     (wrap),
        .cmp_hit  (cmp_hit)
    );

    assign irq = upd_flag && ien_q;

endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wdata0,
    input logic              run,
    input cmode_e            mode,
    input logic              dir_sw,
    input logic              one_shot,
    input logic              ug,
    input logic              load,
    input logic              wrap,
    input logic [W-1:0]      cnt,
    input logic [W-1:0]      top,
    input logic              upd_flag
);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !ug && !load) |=> $stable(cnt));

    // R6
    reload_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ug && ((mode != MODE_EDGE) || !dir_sw)) |=> (cnt == '0));

    // R6
    reload_top_chk: assert property (@(posedge clk) disable iff (rst)
        (ug && (mode == MODE_EDGE) && dir_sw) |=> (cnt == $past(top)));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(upd_flag) |-> $past(wr_en && (addr == A_STAT) && !wdata0));

    // R10
    one_shot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (one_shot && wrap) |=> !run);

    // R5
    mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == A_CTRL) && run && (mode == MODE_EDGE))
        |=> (mode == MODE_EDGE));

endmodule

bind gen_timer tmr_chk #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata0   (wdata[0]),
    .run      (ctrl_q.run),
    .mode     (ctrl_q.mode),
    .dir_sw   (ctrl_q.dir),
    .one_shot (ctrl_q.one_shot),
    .ug       (ug),
    .load     (load),
    .wrap     (wrap),
    .cnt      (cnt),
    .top      (top_val),
    .upd_flag (upd_flag)
);

// File: tb/gen_timer_test.sv
`timescale 1ns/1ps
module gen_timer_test;

    localparam int W = 16;
    localparam logic [2:0] R_CTRL = 3'd0, R_IEN = 3'd1, R_STAT = 3'd2, R_RELOAD = 3'd3,
                           R_CNT = 3'd4, R_DIV = 3'd5, R_TOP = 3'd6, R_CMP = 3'd7;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   addr = 3'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         irq;

    int total = 0;
    int failed = 0;

    gen_timer #(.CNT_W(W)) uut (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [2:0] a, input int d);
        addr  = a;
        wdata = W'(d);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    // Expected count after t ticks. kind: 0 up, 1 down, otherwise symmetric.
    function automatic int pos(input int kind, input int a, input int t);
        int m;
        if (kind == 0) return t % (a + 1);
        if (kind == 1) return a - (t % (a + 1));
        m = t % (2 * a);
        return (m <= a) ? m : 2 * a - m;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        failed++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        int v;
        int v2;
        int A;
        int P;
        int C;
        int md;
        int cfg;
        int first;
        int tk;
        int p;
        int q;
        logic up;
        logic ok;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every register and the interrupt line
        for (int ad = 0; ad < 8; ad++) begin
            rd(3'(ad), v);
            check($sformatf("R1 reset value of address %0d", ad), v, 0);
            @(negedge clk);
        end
        check("R1 irq after reset", int'(irq), 0);

        // R5: mode change from 00 refused while running, other fields kept
        wr(R_CTRL, 1);
        wr(R_CTRL, 1 | 4 | 16);
        rd(R_CTRL, v);
        check("R5 mode locked while running", v, 17);
        wr(R_CTRL, 0);
        wr(R_CTRL, 4);
        rd(R_CTRL, v);
        check("R5 mode accepted while stopped", v, 4);
        wr(R_CTRL, 0);

        // R4: direction bit not writable in a symmetric mode
        wr(R_CTRL, 12);
        wr(R_RELOAD, 1);
        wr(R_CTRL, 12 | 2);
        rd(R_CTRL, v);
        check("R4 dir write ignored in symmetric mode", v, 12);
        wr(R_CTRL, 0);

        // Sweep over modes, top values and divider ratios (R2 R3 R4 R7 R8 R9)
        for (int kind = 0; kind < 5; kind++) begin
            for (int ai = 0; ai < 3; ai++) begin
                for (int pi = 0; pi < 2; pi++) begin
                    A   = (ai == 0) ? 1 : (ai == 1) ? 2 : 4;
                    P   = pi * 2;
                    C   = A / 2;
                    md  = (kind < 2) ? 0 : kind - 1;
                    cfg = (md << 2) | ((kind == 1) ? 2 : 0);
                    first = 1000000;
                    for (int t = 1; t <= 4 * A + 4; t++) begin
                        p  = pos(kind, A, t);
                        q  = pos(kind, A, t - 1);
                        up = (p > q);
                        ok = (kind < 2) || (kind == 4) || (kind == 2 && !up) || (kind == 3 && up);
                        if (ok && p == C && first == 1000000) first = t;
                    end
                    wr(R_CTRL, 0);
                    wr(R_DIV, P);
                    wr(R_TOP, A);
                    wr(R_CMP, C);
                    wr(R_IEN, 1);
                    wr(R_CTRL, cfg);
                    wr(R_RELOAD, 1);
                    wr(R_STAT, 0);
                    wr(R_CTRL, cfg | 1);
                    for (int n = 1; n <= (P + 1) * (2 * A + 2); n++) begin
                        @(negedge clk);
                        tk = n / (P + 1);   // R2 divider: one step per P+1 clocks
                        rd(R_CNT, v);
                        check($sformatf("%s count kind %0d top %0d div %0d edge %0d",
                              (kind < 2) ? "R3" : "R4", kind, A, P, n), v, pos(kind, A, tk));
                        rd(R_STAT, v);
                        check("R7 update flag on wrap", v & 1, int'(tk >= A + 1));
                        check($sformatf("R9 compare flag kind %0d top %0d", kind, A),
                              (v >> 1) & 1, int'(tk >= first));
                        check("R8 irq follows flag and enable", int'(irq), int'(tk >= A + 1));
                        if (kind >= 2) begin
                            rd(R_CTRL, v);
                            check("R4 direction readback", (v >> 1) & 1,
                                  (tk == 0) ? 0 : int'(pos(kind, A, tk) < pos(kind, A, tk - 1)));
                        end
                    end
                end
            end
        end

        // R2: counter holds while stopped
        wr(R_CTRL, 0);
        rd(R_CNT, v);
        repeat (5) @(negedge clk);
        rd(R_CNT, v2);
        check("R2 count holds while stopped", v2, v);

        // R6: reload while counting down loads TOP; RELOAD reads 0
        wr(R_TOP, 9);
        wr(R_DIV, 0);
        wr(R_CTRL, 3);
        repeat (3) @(negedge clk);
        wr(R_RELOAD, 1);
        rd(R_CNT, v);
        check("R6 reload loads top when counting down", v, 9);
        rd(R_RELOAD, v);
        check("R6 reload register reads zero", v, 0);

        // R6: reload clears the divider count
        wr(R_CTRL, 0);
        wr(R_DIV, 2);
        wr(R_CTRL, 1);
        repeat (4) @(negedge clk);
        wr(R_RELOAD, 1);
        rd(R_CNT, v);
        check("R6 reload loads zero counting up", v, 0);
        repeat (2) @(negedge clk);
        rd(R_CNT, v);
        check("R6 no step before full divider period", v, 0);
        @(negedge clk);
        rd(R_CNT, v);
        check("R6 first step after full divider period", v, 1);

        // R7 and R8: update flag gating and software clear
        wr(R_CTRL, 0);
        wr(R_IEN, 0);
        wr(R_STAT, 0);
        wr(R_CTRL, 32);
        wr(R_RELOAD, 1);
        rd(R_STAT, v);
        check("R7 quiet-software blocks reload flag", v & 1, 0);
        wr(R_CTRL, 16);
        wr(R_RELOAD, 1);
        rd(R_STAT, v);
        check("R7 update-off blocks reload flag", v & 1, 0);
        wr(R_CTRL, 0);
        wr(R_RELOAD, 1);
        rd(R_STAT, v);
        check("R7 reload sets flag", v & 1, 1);
        check("R8 irq low with enable clear", int'(irq), 0);
        wr(R_IEN, 1);
        check("R8 irq high with enable set", int'(irq), 1);
        wr(R_STAT, 1);
        rd(R_STAT, v);
        check("R7 writing one keeps flag", v & 1, 1);
        wr(R_STAT, 0);
        rd(R_STAT, v);
        check("R7 writing zero clears flag", v & 1, 0);
        check("R8 irq low after clear", int'(irq), 0);

        // R7: update-off blocks the flag on wraps while counting continues
        wr(R_TOP, 1);
        wr(R_DIV, 0);
        wr(R_CTRL, 16);
        wr(R_RELOAD, 1);
        wr(R_CTRL, 17);
        repeat (6) @(negedge clk);
        rd(R_CNT, v);
        check("R3 counting continues with update-off", v, 0);
        rd(R_STAT, v);
        check("R7 update-off blocks wrap flag", v & 1, 0);

        // R10: one-shot stops the counter at the first wrap
        wr(R_CTRL, 0);
        wr(R_TOP, 3);
        wr(R_RELOAD, 1);
        wr(R_STAT, 0);
        wr(R_CTRL, 65);
        repeat (8) @(negedge clk);
        rd(R_CTRL, v);
        check("R10 run cleared after wrap", v, 64);
        rd(R_CNT, v);
        check("R10 counter stopped on wrapped value", v, 0);
        rd(R_STAT, v);
        check("R10 wrap raised the update flag", v & 1, 1);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule